// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the memory-side controller for a clocked burst read of a flash-style array. A burst is armed when both the latch enable and the chip enable are low. The start address is captured on the first active clock edge after the later of the two falling edges. The block then counts a programmable initial latency. After that it steps through word addresses and presents one array word per data slot. Each word is held for one or two clocks.

Configuration inputs select the burst length (4, 8 or 16 words, or continuous), wrapped or linear addressing, the active clock edge, the data hold time, the initial latency and the WAIT polarity. WAIT marks every clock in which an access is running but no valid data is on the bus: the latency, a single stall in continuous mode, and the time after a fixed burst ends. Raising chip enable ends any access at once. The array is a registered lookup whose content is a function of the address.

Top module: `burst_read_seq`

## Requirements
- R1: A burst starts on the first active clock edge at which both `ce_ni` and `le_ni` are sampled low after at least one of them was high on the previous active edge. The start address `addr_i` is captured on that edge. While only one of the two is low, nothing starts.
- R2: `act_rise_i` = 1 makes the rising edge of `clk_i` the active edge. `act_rise_i` = 0 makes the falling edge active.
- R3: `latency_i` sets the number of active edges from the start edge to the edge that presents the first word. Codes 2 to 7 give that count. Codes 0 and 1 behave as 2.
- R4: `burst_len_i` selects the burst length: 3'b001 gives 4 words, 3'b010 gives 8, 3'b011 gives 16 and 3'b111 gives continuous. Every other code behaves as 4 words.
- R5: With `wrap_i` = 1 and a fixed length of N words, word k is read from address (start with its low log2(N) bits replaced by (start+k) mod N). With `wrap_i` = 0, or in continuous mode, word k is read from start+k. A start address aligned to N gives the same sequence in both modes.
- R6: `hold2_i` = 1 keeps each word on `data_o` for two active clocks. `hold2_i` = 0 keeps it for one.
- R7: WAIT is active during the latency, during a stall, and from the edge after the last word of a fixed burst until chip enable rises or a new burst starts. WAIT is inactive whenever `data_oe_o` is high and whenever the block is idle.
- R8: In continuous mode, one stall clock is inserted before the first word (other than word 0) whose address has its low four bits at zero. No further stall follows in that burst.
- R9: `wait_hi_i` = 1 makes WAIT active high. `wait_hi_i` = 0 makes it active low. The inactive level is the inverse.
- R10: While `ce_ni` is high, `data_oe_o` is 0, `data_o` is zero and WAIT is at its inactive level, without waiting for a clock edge. The burst is dropped and the block is idle from the next active edge.
- R11: A word read from address a equals a XOR 16'h5A00. `data_o` is zero whenever `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_len_i | input | 3 | Burst length code |
| wrap_i | input | 1 | 1: wrap inside the aligned block |
| act_rise_i | input | 1 | 1: rising active edge, 0: falling |
| hold2_i | input | 1 | 1: each word held two clocks |
| wait_hi_i | input | 1 | 1: WAIT active high |
| latency_i | input | 3 | Initial latency code |
| ce_ni | input | 1 | Chip enable, active low |
| le_ni | input | 1 | Latch enable, active low |
| addr_i | input | AW | Burst start address |
| data_o | output | DW | Output word, zero when not driven |
| data_oe_o | output | 1 | Output word valid / bus driven |
| wait_o | output | 1 | WAIT indicator |

## Verification
The bench targets wrap at unaligned starts (5,6,7,0,…). A design that wrapped at the wrong block size, or that did not wrap at all, would present out-of-block addresses. It also checks continuous bursts started both below and on a 16-word boundary. Here a wrong design would stall at every boundary, never stall, or stall one word early.

Further checks cover both latch-enable and chip-enable orderings, the falling-edge mode and the clamped latency codes. A latency counter off by one would shift every word by a clock. Aborts are checked the instant chip enable rises, which catches outputs that are only cleared at the next edge. The bench also checks WAIT after the last word and with low polarity, which catches WAIT stuck inactive at burst end or an inverted level.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAT,
    ST_DATA,
    ST_STALL,
    ST_DONE
  } seq_state_e;

  localparam logic [2:0] LEN_4    = 3'b001;
  localparam logic [2:0] LEN_8    = 3'b010;
  localparam logic [2:0] LEN_16   = 3'b011;
  localparam logic [2:0] LEN_CONT = 3'b111;
  localparam logic [2:0] LAT_MIN  = 3'd2;

  typedef struct packed {
    logic       wrap;
    logic       hold2;
    logic       cont;
    logic [4:0] words;
    logic [3:0] mask;
    logic [2:0] lat;
  } burst_cfg_t;

  function automatic burst_cfg_t decode_cfg(input logic [2:0] len, input logic wrap,
                                            input logic hold2, input logic [2:0] lat);
    burst_cfg_t c;
    c.wrap  = wrap;
    c.hold2 = hold2;
    c.cont  = 1'b0;
    c.lat   = (lat < LAT_MIN) ? LAT_MIN : lat;
    case (len)
      LEN_8:    begin c.words = 5'd8;  c.mask = 4'd7;  end
      LEN_16:   begin c.words = 5'd16; c.mask = 4'd15; end
      LEN_CONT: begin c.words = 5'd0;  c.mask = 4'd15; c.cont = 1'b1; end
      default:  begin c.words = 5'd4;  c.mask = 4'd3;  end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/clk_edge_sel.sv
module clk_edge_sel (
  input  logic clk_i,
  input  logic rise_i,
  output logic clk_o
);
  // Inverting clock mux; select is changed only while the block is idle
  assign clk_o = rise_i ? clk_i : ~clk_i;
endmodule

// File: rtl/burst_start_det.sv
module burst_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic le_ni,
  output logic start_o
);
  logic sel, sel_q;

  assign sel = ~ce_ni & ~le_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel;
  end

  assign start_o = sel & ~sel_q;
endmodule

// File: rtl/burst_array.sv
module burst_array #(
  parameter int          AW      = 16,
  parameter int          DW      = 16,
  parameter logic [15:0] PATTERN = 16'h5A00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam logic [DW-1:0] PAT_W = DW'(PATTERN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (ld_i) data_o <= DW'(addr_i) ^ PAT_W;
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ce_ni,
  input  burst_cfg_t    cfg_i,
  input  logic [AW-1:0] addr_i,
  output logic          ld_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          valid_o,
  output logic          wait_act_o,
  output seq_state_e    state_o,
  output logic          hold_pend_o,
  output logic [2:0]    lat_o,
  output logic          cont_o
);
  localparam int WCW = 5;

  seq_state_e    state_q, state_d;
  burst_cfg_t    cfg_q, cfg_d;
  logic [2:0]    lat_cnt_q, lat_cnt_d;
  logic          hold_q, hold_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic [AW-1:0] nxt_q, nxt_d;
  logic          crossed_q, crossed_d;
  logic          emit;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input burst_cfg_t c);
    logic [AW-1:0] m;
    m = AW'(c.mask);
    if (c.wrap && !c.cont) return (a & ~m) | ((a + 1'b1) & m);
    else                   return a + 1'b1;
  endfunction

  always_comb begin
    state_d   = state_q;
    cfg_d     = cfg_q;
    lat_cnt_d = lat_cnt_q;
    hold_d    = hold_q;
    wcnt_d    = wcnt_q;
    nxt_d     = nxt_q;
    crossed_d = crossed_q;
    emit      = 1'b0;
    if (ce_ni) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      state_d   = ST_LAT;
      cfg_d     = cfg_i;
      lat_cnt_d = cfg_i.lat - 3'd1;
      nxt_d     = addr_i;
      wcnt_d    = '0;
      hold_d    = 1'b0;
      crossed_d = 1'b0;
    end else begin
      case (state_q)
        ST_LAT: begin
          if (lat_cnt_q == 3'd0) emit = 1'b1;
          else                   lat_cnt_d = lat_cnt_q - 3'd1;
        end
        ST_DATA: begin
          if (hold_q) begin
            hold_d = 1'b0;
          end else if (!cfg_q.cont && wcnt_q == cfg_q.words) begin
            state_d = ST_DONE;
          end else if (cfg_q.cont && !crossed_q && nxt_q[3:0] == 4'd0) begin
            state_d   = ST_STALL;
            crossed_d = 1'b1;
          end else begin
            emit = 1'b1;
          end
        end
        ST_STALL: emit = 1'b1;
        default: ;
      endcase
      if (emit) begin
        state_d = ST_DATA;
        hold_d  = cfg_q.hold2;
        nxt_d   = step(nxt_q, cfg_q);
        wcnt_d  = wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cfg_q     <= '0;
      lat_cnt_q <= '0;
      hold_q    <= 1'b0;
      wcnt_q    <= '0;
      nxt_q     <= '0;
      crossed_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cfg_q     <= cfg_d;
      lat_cnt_q <= lat_cnt_d;
      hold_q    <= hold_d;
      wcnt_q    <= wcnt_d;
      nxt_q     <= nxt_d;
      crossed_q <= crossed_d;
    end
  end

  assign ld_o        = emit;
  assign rd_addr_o   = nxt_q;
  assign valid_o     = (state_q == ST_DATA);
  assign wait_act_o  = (state_q == ST_LAT) || (state_q == ST_STALL) || (state_q == ST_DONE);
  assign state_o     = state_q;
  assign hold_pend_o = (state_q == ST_DATA) && hold_q;
  assign lat_o       = cfg_q.lat;
  assign cont_o      = cfg_q.cont;
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 16,
  parameter logic [15:0] PATTERN = 16'h5A00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    burst_len_i,
  input  logic          wrap_i,
  input  logic          act_rise_i,
  input  logic          hold2_i,
  input  logic          wait_hi_i,
  input  logic [2:0]    latency_i,
  input  logic          ce_ni,
  input  logic          le_ni,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          wait_o
);
  logic          act_clk;
  logic          start;
  logic          ld;
  logic [AW-1:0] rd_addr;
  logic          valid;
  logic          wait_act;
  seq_state_e    state;
  logic          hold_pend;
  logic [2:0]    lat;
  logic          cont;
  logic [DW-1:0] arr_data;
  burst_cfg_t    cfg;

  assign cfg = decode_cfg(burst_len_i, wrap_i, hold2_i, latency_i);

  clk_edge_sel i_clk_sel (
    .clk_i (clk_i),
    .rise_i(act_rise_i),
    .clk_o (act_clk)
  );

  burst_start_det i_start (
    .clk_i  (act_clk),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .le_ni  (le_ni),
    .start_o(start)
  );

  burst_ctrl #(.AW(AW)) i_ctrl (
    .clk_i      (act_clk),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .ce_ni      (ce_ni),
    .cfg_i      (cfg),
    .addr_i     (addr_i),
    .ld_o       (ld),
    .rd_addr_o  (rd_addr),
    .valid_o    (valid),
    .wait_act_o (wait_act),
    .state_o    (state),
    .hold_pend_o(hold_pend),
    .lat_o      (lat),
    .cont_o     (cont)
  );

  burst_array #(.AW(AW), .DW(DW), .PATTERN(PATTERN)) i_array (
    .clk_i (act_clk),
    .rst_ni(rst_ni),
    .ld_i  (ld),
    .addr_i(rd_addr),
    .data_o(arr_data)
  );

  // Chip enable gates the bus without waiting for an edge
  assign data_oe_o = valid & ~ce_ni;
  assign data_o    = data_oe_o ? arr_data : '0;
  assign wait_o    = (wait_act & ~ce_ni) ? wait_hi_i : ~wait_hi_i;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          pol_i,
  input  logic          start_i,
  input  seq_state_e    state_i,
  input  logic          hold_pend_i,
  input  logic [2:0]    lat_i,
  input  logic          cont_i,
  input  logic [DW-1:0] data_i,
  input  logic          data_oe_i,
  input  logic          wait_i
);
  logic [3:0] edge_cnt;
  logic       first_pend;
  logic [1:0] stall_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt   <= '0;
      first_pend <= 1'b0;
      stall_cnt  <= '0;
    end else if (ce_ni) begin
      edge_cnt   <= '0;
      first_pend <= 1'b0;
      stall_cnt  <= '0;
    end else if (start_i) begin
      edge_cnt   <= 4'd1;
      first_pend <= 1'b1;
      stall_cnt  <= '0;
    end else begin
      if (edge_cnt != 4'd0 && edge_cnt != 4'hF) edge_cnt <= edge_cnt + 4'd1;
      if (data_oe_i) first_pend <= 1'b0;
      if (state_i == ST_STALL && stall_cnt != 2'd3) stall_cnt <= stall_cnt + 2'd1;
    end
  end

  a_r10_ce_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (!data_oe_i && data_i == '0 && wait_i == ~pol_i));

  a_r7_no_wait_when_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_i |-> (wait_i != pol_i));

  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_pend_i && !ce_ni) |=> (ce_ni || !data_oe_i || $stable(data_i)));

  a_r3_first_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_pend && data_oe_i) |-> (edge_cnt == {1'b0, lat_i} + 4'd1));

  a_r8_single_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_cnt <= 2'd1);

  a_r8_stall_cont_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_STALL) |-> cont_i);
endmodule

bind burst_read_seq burst_seq_chk #(.DW(DW)) i_chk (
  .clk_i      (act_clk),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .pol_i      (wait_hi_i),
  .start_i    (start),
  .state_i    (state),
  .hold_pend_i(hold_pend),
  .lat_i      (lat),
  .cont_i     (cont),
  .data_i     (data_o),
  .data_oe_i  (data_oe_o),
  .wait_i     (wait_o)
);

// File: tb/test_burst_read_seq.sv
`timescale 1ns/1ps
module test_burst_read_seq;

  typedef struct {
    logic        drive;
    logic [15:0] data;
    logic        wact;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  burst_len = 3'b001;
  logic        wrap = 1'b1;
  logic        act_rise = 1'b1;
  logic        hold2 = 1'b0;
  logic        wait_hi = 1'b1;
  logic [2:0]  latency = 3'd2;
  logic        ce_n = 1'b1;
  logic        le_n = 1'b1;
  logic [15:0] addr = '0;
  logic [15:0] data;
  logic        data_oe;
  logic        wait_s;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  int   lim_left = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  burst_read_seq i_burst_read_seq (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .burst_len_i(burst_len),
    .wrap_i     (wrap),
    .act_rise_i (act_rise),
    .hold2_i    (hold2),
    .wait_hi_i  (wait_hi),
    .latency_i  (latency),
    .ce_ni      (ce_n),
    .le_ni      (le_n),
    .addr_i     (addr),
    .data_o     (data),
    .data_oe_o  (data_oe),
    .wait_o     (wait_s)
  );

  task automatic act_edge();
    if (act_rise) @(posedge clk);
    else          @(negedge clk);
  endtask

  function automatic logic [15:0] word_of(input logic [15:0] a);
    return a ^ 16'h5A00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push_item(input logic drv, input logic [15:0] d, input logic wact,
                           input string req);
    exp_t it;
    if (lim_left == 0) return;
    lim_left--;
    it.drive = drv; it.data = d; it.wact = wact; it.req = req;
    exp_q.push_back(it);
  endtask

  // Monitor: one expected item per active edge, sampled 1 ns after it
  initial begin
    forever begin
      act_edge();
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check(data_oe == it.drive, it.req, "data_oe", 16'(data_oe), 16'(it.drive));
        check(wait_s == (it.wact ? wait_hi : ~wait_hi), it.req, "wait",
              16'(wait_s), 16'(it.wact ? wait_hi : ~wait_hi));
        if (it.drive) check(data == it.data, it.req, "data", data, it.data);
      end
    end
  end

  // mode 0: both fall together, 1: le first, 2: ce first. max_items 0 = all
  task automatic run_burst(input logic [2:0] len, input logic wr, input logic rise,
                           input logic h2, input logic pol, input logic [2:0] lat,
                           input logic [15:0] a, input int mode, input int cont_words,
                           input int max_items, input string tag);
    int          lcl, n, hcnt;
    bit          cont, stalled;
    logic [15:0] m, wa;
    burst_len = len; wrap = wr; act_rise = rise; hold2 = h2; wait_hi = pol;
    latency = lat; addr = a;
    repeat (2) act_edge();
    #3;
    if (mode == 1) begin le_n = 1'b0; repeat (3) act_edge(); #3; end
    if (mode == 2) begin ce_n = 1'b0; repeat (3) act_edge(); #3; end
    ce_n = 1'b0; le_n = 1'b0;
    lcl  = (lat < 3'd2) ? 2 : int'(lat);
    cont = 0;
    case (len)
      3'b001: n = 4;
      3'b010: n = 8;
      3'b011: n = 16;
      3'b111: begin n = cont_words; cont = 1; end
      default: n = 4;
    endcase
    m = 16'(n - 1);
    hcnt = h2 ? 2 : 1;
    lim_left = (max_items == 0) ? 100000 : max_items;
    stalled = 0;
    for (int i = 0; i < lcl; i++) push_item(1'b0, '0, 1'b1, {tag, " R3 R7 latency"});
    for (int k = 0; k < n; k++) begin
      if (wr && !cont) wa = (a & ~m) | ((a + 16'(k)) & m);
      else             wa = a + 16'(k);
      if (cont && k > 0 && !stalled && wa[3:0] == 4'd0) begin
        stalled = 1;
        push_item(1'b0, '0, 1'b1, {tag, " R8 stall"});
      end
      for (int h = 0; h < hcnt; h++) push_item(1'b1, word_of(wa), 1'b0, {tag, " R5 R6 R11 word"});
    end
    if (!cont) for (int i = 0; i < 2; i++) push_item(1'b0, '0, 1'b1, {tag, " R4 R7 end"});
    wait (exp_q.size() == 0);
    #2;
    ce_n = 1'b1;
    #1;
    check(!data_oe && data == '0, {tag, " R10"}, "bus after ce high", data, 16'h0);
    check(wait_s == ~pol, {tag, " R10 R9"}, "wait after ce high", 16'(wait_s), 16'(~pol));
    lim_left = 2;
    push_item(1'b0, '0, 1'b0, {tag, " R10 idle"});
    push_item(1'b0, '0, 1'b0, {tag, " R10 idle"});
    wait (exp_q.size() == 0);
    #2;
    le_n = 1'b1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #20;
    rst_n = 1'b1;
    #5;
    check(!data_oe && data == '0, "R11 reset", "bus", data, 16'h0);
    check(wait_s == 1'b0, "R7 R9 reset", "wait", 16'(wait_s), 16'h0);
    // R4 R5 aligned 4-word wrap
    run_burst(3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 16'h0100, 0, 0, 0, "t1");
    // R5 aligned no-wrap equals wrap
    run_burst(3'b001, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 16'h0100, 0, 0, 0, "t2");
    // R5 unaligned 8-word wrap and linear
    run_burst(3'b010, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 16'h0105, 0, 0, 0, "t3");
    run_burst(3'b010, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 16'h0105, 0, 0, 0, "t4");
    // R6 R9 16-word wrap, hold two, active-low wait
    run_burst(3'b011, 1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 16'h0023, 0, 0, 0, "t5");
    // R8 continuous unaligned and aligned starts
    run_burst(3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 16'h003A, 0, 12, 0, "t6");
    run_burst(3'b111, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 16'h0040, 0, 20, 0, "t7");
    // R2 R1 falling edge, le falls first
    run_burst(3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 3'd7, 16'h0206, 1, 0, 0, "t8");
    // R1 ce falls first
    run_burst(3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 16'h0311, 2, 0, 0, "t9");
    // R10 abort in the middle of a burst
    run_burst(3'b011, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3, 16'h0400, 0, 0, 5, "t10");
    // R3 latency code 0 behaves as 2
    run_burst(3'b001, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 16'h0500, 0, 0, 0, "t11");
    // R4 reserved length code behaves as 4
    run_burst(3'b100, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 16'h0602, 0, 0, 0, "t12");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule